// File: doc/BRIEF.md
# Sprite Hit Detection and Pixel Compositor

This block chooses the colour of every screen pixel by placing a set of freely positioned 16x16 foreground sprites over the background layer. Each sprite slot keeps a private cached copy of one attribute word. The cache is refilled from host-written attribute memory only while vertical blanking is asserted, so the host can rewrite that memory during active display without tearing the picture.

For each screen coordinate presented on the pixel inputs, every slot tests in parallel whether the pixel lies inside its sprite. A slot that hits computes the in-sprite row and column, applying horizontal and vertical flips, and issues a pattern-memory read address on its own request port. One cycle later the pattern memory returns a 3-bit colour index for every slot. The compositor then takes the lowest-numbered slot whose returned index is non-zero and outputs that slot's palette number with the index. When no slot qualifies, it outputs the background pixel, which it delays to keep it aligned with the sprite pixels. There is no limit on how many sprites may share a scanline.

Top module: `sprite_compositor`

## Requirements
- R1: After reset, both output fields are 0. Every cached slot holds x = 511 and y = 255, which places every sprite fully off-screen for screen x in 0..255 and screen y in 0..223. Until the first load, every pixel therefore shows the background.
- R2: A slot with stored position (sx, sy) covers screen pixel (x, y) when x + 15 − sx and y + 15 − sy both lie in 0..15. A stored 0 therefore places the sprite edge 15 pixels before the screen edge.
- R3: The pattern request address of a slot is {tile[9:0], row[3:0], col[3:0]}, where col = x + 15 − sx and row = y + 15 − sy before flipping.
- R4: When the horizontal flip bit is set, the column becomes 15 − col.
- R5: When the vertical flip bit is set, the row becomes 15 − row.
- R6: A returned colour index of 0 is transparent. That slot is then skipped, and a lower-priority slot or the background shows through.
- R7: Among the slots that hit with a non-transparent pixel, the one with the lowest index wins.
- R8: When no slot wins, the output is the background palette and colour index presented with that pixel.
- R9: The output carries the winning slot's 3-bit palette number and the 3-bit colour index that pattern memory returned for it.
- R10: The output for a pixel appears on the third rising edge after the pixel is presented. Pattern memory returns data one edge after the request.
- R11: Attribute word layout: [8:0] x, [16:9] y, [26:17] tile, [29:27] palette, [30] vertical flip, [31] horizontal flip. The word at address i loads slot i, and loads happen only while vblank is high. A change to attribute memory during active display has no effect on the output until the next vblank.
- R12: A sprite whose position is partly off the top or left edge is drawn clipped, showing only its on-screen pixels.
- R13: Every slot can be visible on the same scanline at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank | input | 1 | Vertical blanking; enables cache reloads |
| attr_rd_en | output | 1 | Attribute memory read enable |
| attr_rd_addr | output | IDX_W | Attribute memory read address (slot number) |
| attr_rd_data | input | 32 | Attribute word, valid one cycle after the read |
| pix_x | input | 9 | Current screen x |
| pix_y | input | 8 | Current screen y |
| bg_pal | input | 3 | Background palette for this pixel |
| bg_cidx | input | 3 | Background colour index for this pixel |
| pat_addr | output | NUM_SLOTS*18 | Per-slot pattern request address |
| pat_data | input | NUM_SLOTS*3 | Per-slot returned colour index |
| out_pal | output | 3 | Composited palette number |
| out_cidx | output | 3 | Composited colour index |

## Verification
The assertions check on every cycle that cache loads occur only inside vblank and target a valid slot, that the compositor never selects more than one slot, and that whenever any slot qualifies the output index is non-zero. The bench scenarios show the geometry itself: the −15 bias, edge clipping, both flips, fall-through on transparent pixels, priority between overlapping sprites, the three-edge latency, and the rule that attribute changes wait for the next vblank.

// File: rtl/sprite_pkg.sv
package sprite_pkg;
  localparam int X_W      = 9;
  localparam int Y_W      = 8;
  localparam int TILE_W   = 10;
  localparam int PAL_W    = 3;
  localparam int CIDX_W   = 3;
  localparam int OFS_W    = 4;              // 16x16 sprites
  localparam int SPR_BIAS = (1 << OFS_W) - 1; // position bias of -15
  localparam int PAT_ADDR_W = TILE_W + 2 * OFS_W;

  typedef struct packed {
    logic              hflip;
    logic              vflip;
    logic [PAL_W-1:0]  pal;
    logic [TILE_W-1:0] tile;
    logic [Y_W-1:0]    ypos;
    logic [X_W-1:0]    xpos;
  } spr_attr_t;

  localparam int ATTR_W = $bits(spr_attr_t);

  function automatic spr_attr_t parked_attr();
    spr_attr_t a;
    a       = '0;
    a.xpos  = '1;
    a.ypos  = '1;
    return a;
  endfunction
endpackage

// File: rtl/sprite_attr_loader.sv
module sprite_attr_loader
  import sprite_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vblank,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_slot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             req_q, req_d;
  logic [IDX_W-1:0] slot_q, slot_d;

  always_comb begin
    idx_d  = '0;
    if (vblank) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    req_d  = vblank;
    slot_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      req_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      idx_q  <= idx_d;
      req_q  <= req_d;
      slot_q <= slot_d;
    end
  end

  assign rd_en   = vblank;
  assign rd_addr = idx_q;
  assign wr_en   = req_q & vblank;
  assign wr_slot = slot_q;

  // R11
  load_in_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> vblank && $past(vblank));

  // R11
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (int'(rd_addr) < NUM_SLOTS));
endmodule

// File: rtl/sprite_slot.sv
module sprite_slot
  import sprite_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [ATTR_W-1:0]     load_word,
  input  logic [X_W-1:0]        pix_x,
  input  logic [Y_W-1:0]        pix_y,
  output logic [PAT_ADDR_W-1:0] pat_addr,
  output logic                  hit_o,
  output logic [PAL_W-1:0]      pal_o
);
  spr_attr_t cache_q, cache_d;

  // geometry, one guard bit above the coordinate for the bias
  logic [X_W+1:0]    ax, bx, dx;
  logic [Y_W+1:0]    ay, by, dy;
  logic              in_x, in_y;
  logic [OFS_W-1:0]  col, row;

  logic                  hit1_q, hit1_d, hit2_q;
  logic [PAL_W-1:0]      pal1_q, pal1_d, pal2_q;
  logic [PAT_ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    cache_d = load_en ? spr_attr_t'(load_word) : cache_q;
  end

  always_comb begin
    ax   = {2'b00, pix_x} + (X_W+2)'(SPR_BIAS);
    bx   = {2'b00, cache_q.xpos};
    dx   = ax - bx;
    in_x = (ax >= bx) && (dx[X_W+1:OFS_W] == '0);
    ay   = {2'b00, pix_y} + (Y_W+2)'(SPR_BIAS);
    by   = {2'b00, cache_q.ypos};
    dy   = ay - by;
    in_y = (ay >= by) && (dy[Y_W+1:OFS_W] == '0);
    col  = cache_q.hflip ? ~dx[OFS_W-1:0] : dx[OFS_W-1:0];
    row  = cache_q.vflip ? ~dy[OFS_W-1:0] : dy[OFS_W-1:0];
    hit1_d = in_x & in_y;
    pal1_d = cache_q.pal;
    addr_d = {cache_q.tile, row, col};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_q <= parked_attr();
      hit1_q  <= 1'b0;
      pal1_q  <= '0;
      addr_q  <= '0;
      hit2_q  <= 1'b0;
      pal2_q  <= '0;
    end else begin
      cache_q <= cache_d;
      hit1_q  <= hit1_d;
      pal1_q  <= pal1_d;
      addr_q  <= addr_d;
      hit2_q  <= hit1_q;
      pal2_q  <= pal1_q;
    end
  end

  assign pat_addr = addr_q;
  assign hit_o    = hit2_q;
  assign pal_o    = pal2_q;
endmodule

// File: rtl/sprite_priority_mux.sv
module sprite_priority_mux
  import sprite_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        hit,
  input  logic [NUM_SLOTS*PAL_W-1:0]  pal,
  input  logic [NUM_SLOTS*CIDX_W-1:0] cidx,
  input  logic [PAL_W-1:0]            bg_pal,
  input  logic [CIDX_W-1:0]           bg_cidx,
  output logic [PAL_W-1:0]            out_pal,
  output logic [CIDX_W-1:0]           out_cidx
);
  logic [NUM_SLOTS-1:0] cand, sel;
  logic [PAL_W-1:0]     pal_d, pal_q;
  logic [CIDX_W-1:0]    cidx_d, cidx_q;
  logic                 any;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++)
      cand[i] = hit[i] && (cidx[i*CIDX_W +: CIDX_W] != '0);
  end

  // lowest-index candidate as a one-hot select
  always_comb begin
    logic seen;
    seen = 1'b0;
    sel  = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      sel[i] = cand[i] & ~seen;
      seen   = seen | cand[i];
    end
  end

  always_comb begin
    logic [PAL_W-1:0]  p;
    logic [CIDX_W-1:0] c;
    p = '0;
    c = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      p = p | ({PAL_W{sel[i]}}  & pal[i*PAL_W +: PAL_W]);
      c = c | ({CIDX_W{sel[i]}} & cidx[i*CIDX_W +: CIDX_W]);
    end
    any    = |cand;
    pal_d  = any ? p : bg_pal;
    cidx_d = any ? c : bg_cidx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_q  <= '0;
      cidx_q <= '0;
    end else begin
      pal_q  <= pal_d;
      cidx_q <= cidx_d;
    end
  end

  assign out_pal  = pal_q;
  assign out_cidx = cidx_q;

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R6
  sprite_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand) |=> (out_cidx != '0));
endmodule

// File: rtl/sprite_compositor.sv
module sprite_compositor
  import sprite_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           vblank,
  output logic                           attr_rd_en,
  output logic [IDX_W-1:0]               attr_rd_addr,
  input  logic [ATTR_W-1:0]              attr_rd_data,
  input  logic [X_W-1:0]                 pix_x,
  input  logic [Y_W-1:0]                 pix_y,
  input  logic [PAL_W-1:0]               bg_pal,
  input  logic [CIDX_W-1:0]              bg_cidx,
  output logic [NUM_SLOTS*PAT_ADDR_W-1:0] pat_addr,
  input  logic [NUM_SLOTS*CIDX_W-1:0]    pat_data,
  output logic [PAL_W-1:0]               out_pal,
  output logic [CIDX_W-1:0]              out_cidx
);
  logic                       wr_en;
  logic [IDX_W-1:0]           wr_slot;
  logic [NUM_SLOTS-1:0]       hit;
  logic [NUM_SLOTS*PAL_W-1:0] pal;

  logic [PAL_W-1:0]  bgp1_q, bgp2_q;
  logic [CIDX_W-1:0] bgc1_q, bgc2_q;

  sprite_attr_loader #(.NUM_SLOTS(NUM_SLOTS)) u_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .vblank  (vblank),
    .rd_en   (attr_rd_en),
    .rd_addr (attr_rd_addr),
    .wr_en   (wr_en),
    .wr_slot (wr_slot)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic ld;
    assign ld = wr_en && (wr_slot == IDX_W'(g));
    sprite_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (ld),
      .load_word (attr_rd_data),
      .pix_x     (pix_x),
      .pix_y     (pix_y),
      .pat_addr  (pat_addr[g*PAT_ADDR_W +: PAT_ADDR_W]),
      .hit_o     (hit[g]),
      .pal_o     (pal[g*PAL_W +: PAL_W])
    );
  end

  // background follows the two sprite stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bgp1_q <= '0;
      bgc1_q <= '0;
      bgp2_q <= '0;
      bgc2_q <= '0;
    end else begin
      bgp1_q <= bg_pal;
      bgc1_q <= bg_cidx;
      bgp2_q <= bgp1_q;
      bgc2_q <= bgc1_q;
    end
  end

  sprite_priority_mux #(.NUM_SLOTS(NUM_SLOTS)) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .pal      (pal),
    .cidx     (pat_data),
    .bg_pal   (bgp2_q),
    .bg_cidx  (bgc2_q),
    .out_pal  (out_pal),
    .out_cidx (out_cidx)
  );
endmodule

// File: tb/sprite_compositor_bench.sv
module sprite_compositor_bench;
  import sprite_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vblank = 1'b0;
  logic attr_rd_en;
  logic [IW-1:0] attr_rd_addr;
  logic [31:0] attr_rd_data = '0;
  logic [8:0] pix_x = '0;
  logic [7:0] pix_y = '0;
  logic [2:0] bg_pal = '0, bg_cidx = '0;
  logic [N*18-1:0] pat_addr;
  logic [N*3-1:0] pat_data = '0;
  logic [2:0] out_pal, out_cidx;

  logic [31:0] attr_mem [N];
  logic [31:0] shadow [N];
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sprite_compositor #(.NUM_SLOTS(N)) u_sprite_compositor (
    .clk(clk), .rst_n(rst_n), .vblank(vblank),
    .attr_rd_en(attr_rd_en), .attr_rd_addr(attr_rd_addr), .attr_rd_data(attr_rd_data),
    .pix_x(pix_x), .pix_y(pix_y), .bg_pal(bg_pal), .bg_cidx(bg_cidx),
    .pat_addr(pat_addr), .pat_data(pat_data), .out_pal(out_pal), .out_cidx(out_cidx)
  );

  // pattern colour = (tile + row + col) mod 8, one-cycle read
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      logic [17:0] a;
      a = pat_addr[i*18 +: 18];
      pat_data[i*3 +: 3] <= 3'(a[17:8] + 10'(a[7:4]) + 10'(a[3:0]));
    end
    if (attr_rd_en) attr_rd_data <= attr_mem[attr_rd_addr];
  end

  function automatic logic [31:0] mk(int x, int y, int tile, int pal, bit v, bit h);
    return {h, v, 3'(pal), 10'(tile), 8'(y), 9'(x)};
  endfunction

  // expected {pal, cidx} from the requirements
  function automatic logic [5:0] model(int x, int y, logic [2:0] bp, logic [2:0] bc);
    for (int i = 0; i < N; i++) begin
      int dx, dy, col, row, c;
      dx = x + 15 - int'(shadow[i][8:0]);
      dy = y + 15 - int'(shadow[i][16:9]);
      if (dx >= 0 && dx <= 15 && dy >= 0 && dy <= 15) begin
        col = shadow[i][31] ? 15 - dx : dx;   // R4
        row = shadow[i][30] ? 15 - dy : dy;   // R5
        c = (int'(shadow[i][26:17]) + row + col) % 8;
        if (c != 0) return {shadow[i][29:27], 3'(c)};  // R7 first wins
      end
    end
    return {bp, bc};  // R8
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual pal=%0d cidx=%0d expected pal=%0d cidx=%0d",
               tag, act[5:3], act[2:0], exp[5:3], exp[2:0]);
    end
  endtask

  task automatic drive(int x, int y, logic [2:0] bp, logic [2:0] bc);
    @(negedge clk);
    pix_x = 9'(x); pix_y = 8'(y); bg_pal = bp; bg_cidx = bc;
  endtask

  task automatic pixel(string tag, int x, int y, logic [2:0] bp, logic [2:0] bc);
    drive(x, y, bp, bc);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tag, {out_pal, out_cidx}, model(x, y, bp, bc));
  endtask

  task automatic do_vblank();
    @(negedge clk); vblank = 1'b1;
    repeat (2*N + 4) @(posedge clk);
    @(negedge clk); vblank = 1'b0;
    for (int i = 0; i < N; i++) shadow[i] = attr_mem[i];
  endtask

  localparam int NV = 13;
  localparam int VX [NV] = '{15, 12, 10, 24, 24,  0,  1,  0, 20, 21,  4,  5, 200};
  localparam int VY [NV] = '{15, 11,  5, 21,  9,  0,  0,  1, 20, 20,  5,  5, 100};
  // tags: R7 overlap, R6 fall to slot1, R6 to bg, R4 hflip, R6/R5 to slot3,
  // R12 clipped corner, R12 outside, R12 outside, R2 far corner, R2 beyond,
  // R2 before, R3 origin, R8 empty
  localparam int VT [NV] = '{7, 6, 6, 4, 5, 12, 12, 12, 2, 2, 2, 3, 8};

  initial begin
    for (int i = 0; i < N; i++) begin attr_mem[i] = '0; shadow[i] = {1'b0,1'b0,3'd0,10'd0,8'd255,9'd511}; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset output", {out_pal, out_cidx}, 6'd0);
    rst_n = 1'b1;
    pixel("R1 parked slots", 0, 0, 3'd5, 3'd6);
    pixel("R1 parked slots", 255, 223, 3'd2, 3'd0);

    attr_mem[0] = mk(20, 20, 3, 1, 0, 0);
    attr_mem[1] = mk(25, 22, 5, 2, 0, 1);
    attr_mem[2] = mk( 0,  0, 2, 3, 1, 0);
    attr_mem[3] = mk(25, 22, 6, 4, 1, 1);
    do_vblank();

    for (int v = 0; v < NV; v++)
      pixel($sformatf("R%0d vector %0d", VT[v], v), VX[v], VY[v], 3'(v), 3'(v+1));

    // R9: overlap pixel shows slot0 palette 1, index 7
    pixel("R9 palette field", 15, 15, 3'd0, 3'd0);
    check("R9 explicit", {out_pal, out_cidx}, {3'd1, 3'd7});

    // R10: output changes on the third edge, not the second
    drive(15, 15, 3'd0, 3'd0);
    repeat (3) @(posedge clk);
    drive(200, 100, 3'd6, 3'd5);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 before third edge", {out_pal, out_cidx}, {3'd1, 3'd7});
    @(posedge clk); @(negedge clk);
    check("R10 at third edge", {out_pal, out_cidx}, {3'd6, 3'd5});

    // R11: rewrite during active display, no effect before vblank
    for (int i = 0; i < N; i++) attr_mem[i] = mk(100 + 30*i, 50, 4, 4 + i, 0, 0);
    repeat (20) @(posedge clk);
    pixel("R11 ignored outside vblank", 15, 15, 3'd0, 3'd0);
    check("R11 old cache kept", {out_pal, out_cidx}, {3'd1, 3'd7});
    pixel("R11 new spot still bg", 85, 36, 3'd7, 3'd7);
    check("R11 new spot bg", {out_pal, out_cidx}, {3'd7, 3'd7});
    do_vblank();
    pixel("R11 old spot cleared", 15, 15, 3'd2, 3'd3);

    // R13: all slots on one scanline
    for (int i = 0; i < N; i++) begin
      pixel("R13 same line", 85 + 30*i, 36, 3'd0, 3'd0);
      check("R13 slot visible", {out_pal, out_cidx}, {3'(4 + i), 3'd5});
    end

    // R1: reset clears caches
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", {out_pal, out_cidx}, 6'd0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) shadow[i] = {1'b0,1'b0,3'd0,10'd0,8'd255,9'd511};
    pixel("R1 cache cleared", 85, 36, 3'd3, 3'd4);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule